// File: doc/BRIEF.md
# One-Shot Boot Strap Sampler

This block takes a single snapshot of a bank of general-purpose input pins and keeps it as the boot strap word. The power-management controller raises an enable input after reset. On the first clock cycle in which that enable is high, the pin word is stored and a valid flag is set. Every later enable is ignored until the next reset. The stored word and the flag drive a sampled-straps output. Software can also read them through a small read-only register port.

A build-time parameter removes the feature. In that build the stored word, the flag and both registers always read as zero. The pins are assumed to be synchronous to the clock already. Reset is asynchronous and active-low; it clears the snapshot and arms the capture again.

Top module: `strap_latch`

## Requirements
- R1: With the feature enabled, the first rising clock edge after reset at which `strap_en_i` is high stores `pins_i` into `straps_data_o`. The new value is visible after that edge.
- R2: After the first capture, later enable pulses leave `straps_data_o` and `straps_valid_o` unchanged until the next reset. This holds even when `pins_i` differs at the time of those pulses.
- R3: A read at offset 0x44 returns the stored strap word. A read at offset 0x40 returns the valid flag in bit 0, with all other bits zero. Read data appears on `reg_rdata_o` in the cycle after the clock edge that samples `reg_re_i`.
- R4: `straps_valid_o` rises on the same edge that stores the data, so data and valid appear together.
- R5: While `rst_ni` is low, and right after it is released, the stored word, the flag and `reg_rdata_o` are zero. A new capture is then possible.
- R6: When `FeatureOn` is 0, the following all stay zero whatever the enable and the pins do:
  - `straps_data_o`
  - `straps_valid_o`
  - both registers
- R7: A read at any offset other than 0x40 and 0x44 returns zero. `reg_rdata_o` is zero in any cycle that follows an edge without a read.
- R8: Register writes through `reg_we_i` and `reg_wdata_i`, at any offset, change neither the stored word nor the flag.
- R9: If the enable is held high for several cycles, only its first high cycle captures. Pin changes during the later high cycles are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | 1 | Capture enable from the power controller |
| pins_i | input | PinWidth | Synchronized input pin word |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe (ignored) |
| reg_addr_i | input | AddrWidth | Register byte offset |
| reg_wdata_i | input | RegWidth | Register write data (ignored) |
| reg_rdata_o | output | RegWidth | Registered read data |
| straps_data_o | output | PinWidth | Captured strap word |
| straps_valid_o | output | 1 | Strap word has been captured |

## Verification
The capture changes the sampled-straps output on the edge that samples the enable. The bench therefore drives the enable at a falling edge and checks the output at the following falling edge. A read result arrives one edge after its strobe. The read task pushes the expected word into a queue when it raises the strobe. The monitor pops that word at the next falling edge, after the registered read data has settled. Reset clearing is checked while reset is still asserted, with no clock edge involved.

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned PinWidth  = 32,
  parameter int unsigned RegWidth  = 32,
  parameter int unsigned AddrWidth = 8,
  parameter bit          FeatureOn = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strap_en_i,
  input  logic [PinWidth-1:0]  pins_i,
  input  logic                 reg_re_i,
  input  logic                 reg_we_i,
  input  logic [AddrWidth-1:0] reg_addr_i,
  input  logic [RegWidth-1:0]  reg_wdata_i,
  output logic [RegWidth-1:0]  reg_rdata_o,
  output logic [PinWidth-1:0]  straps_data_o,
  output logic                 straps_valid_o
);

  localparam logic [AddrWidth-1:0] ValidOffset = AddrWidth'(8'h40);
  localparam logic [AddrWidth-1:0] DataOffset  = AddrWidth'(8'h44);

  logic [PinWidth-1:0] snap_q;
  logic                taken_q;
  logic [RegWidth-1:0] rd_mux;
  logic                unused_wr;

  assign unused_wr = reg_we_i ^ (^reg_wdata_i);

  if (FeatureOn) begin : g_on
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        snap_q  <= '0;
        taken_q <= 1'b0;
      end else if (strap_en_i && !taken_q) begin
        snap_q  <= pins_i;
        taken_q <= 1'b1;
      end
    end

    AST_FIRST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strap_en_i && !straps_valid_o) |=> (straps_valid_o && straps_data_o == $past(pins_i))) // R1
      else $error("capture missed");
  end else begin : g_off
    assign snap_q  = '0;
    assign taken_q = 1'b0;

    AST_OFF_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_re_i |=> reg_rdata_o == '0) // R6
      else $error("disabled build returned data");
  end

  assign straps_data_o  = snap_q;
  assign straps_valid_o = taken_q;

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == DataOffset)       rd_mux = RegWidth'(snap_q);
    else if (reg_addr_i == ValidOffset) rd_mux = RegWidth'(taken_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else         reg_rdata_o <= reg_re_i ? rd_mux : '0;
  end

  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    straps_valid_o |=> (straps_valid_o && $stable(straps_data_o))) // R2
    else $error("snapshot changed after capture");

  AST_VALID_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(straps_valid_o) |-> $past(strap_en_i)) // R4
    else $error("valid rose without enable");

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> reg_rdata_o == '0) // R7
    else $error("read data without strobe");

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i != DataOffset && reg_addr_i != ValidOffset) |=> reg_rdata_o == '0) // R7
    else $error("unmapped offset returned data");

  AST_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !strap_en_i) |=> ($stable(straps_data_o) && $stable(straps_valid_o))) // R8
    else $error("write changed snapshot");

endmodule

// File: tb/test_strap_latch.sv
module test_strap_latch;
  localparam int W = 32;
  localparam logic [7:0] A_VALID = 8'h40;
  localparam logic [7:0] A_DATA  = 8'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] pins = '0;
  logic re = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, rdata_off, sdata, sdata_off;
  logic svalid, svalid_off;

  int tests = 0, fails = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic pend = 1'b0;

  always #4 clk = ~clk;

  strap_latch i_strap_latch (
    .clk_i(clk), .rst_ni(rst_n), .strap_en_i(en), .pins_i(pins),
    .reg_re_i(re), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .straps_data_o(sdata), .straps_valid_o(svalid));

  strap_latch #(.FeatureOn(1'b0)) i_strap_latch_off (
    .clk_i(clk), .rst_ni(rst_n), .strap_en_i(en), .pins_i(pins),
    .reg_re_i(re), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_off), .straps_data_o(sdata_off), .straps_valid_o(svalid_off));

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0; else pend <= re;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
        check("R6 off-build read", rdata_off, '0);
      end
    end
  end

  task automatic rd(logic [7:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    re = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic pulse(logic [W-1:0] p, int cycles);
    @(negedge clk);
    pins = p; en = 1'b1;
    for (int i = 1; i < cycles; i++) begin
      @(negedge clk);
      pins = ~pins;
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R5 data in reset", sdata, '0);
    check("R5 valid in reset", W'(svalid), '0);
    check("R5 rdata in reset", rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, c;
    a = 32'hA5C3_1E77; b = 32'h0F0F_1234; c = 32'h8001_BEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 data after reset", sdata, '0);
    check("R5 valid after reset", W'(svalid), '0);
    rd(A_VALID, '0, "R5 valid reg after reset");
    rd(A_DATA, '0, "R5 data reg after reset");
    rd(8'h10, '0, "R7 idle unmapped");

    pulse(a, 1);
    check("R1 captured word", sdata, a);
    check("R4 valid with data", W'(svalid), 1);
    check("R6 off data", sdata_off, '0);
    check("R6 off valid", W'(svalid_off), '0);
    rd(A_DATA, a, "R3 data reg");
    rd(A_VALID, 1, "R3 valid reg");
    rd(8'h48, '0, "R7 unmapped 0x48");

    pins = b;
    pulse(b, 1);
    check("R2 second pulse data", sdata, a);
    check("R2 second pulse valid", W'(svalid), 1);
    rd(A_DATA, a, "R2 data reg after second pulse");

    @(negedge clk); we = 1'b1; addr = A_DATA; wdata = 32'hFFFF_FFFF;
    @(negedge clk); addr = A_VALID; wdata = '0;
    @(negedge clk); we = 1'b0;
    rd(A_DATA, a, "R8 data after writes");
    rd(A_VALID, 1, "R8 valid after writes");

    do_reset();
    rd(A_VALID, '0, "R5 valid cleared");
    pulse(c, 3);
    check("R9 held enable captures first cycle", sdata, c);
    check("R5 recapture valid", W'(svalid), 1);
    rd(A_DATA, c, "R9 data reg");
    check("R6 off data after recapture", sdata_off, '0);

    repeat (2) @(negedge clk);
    check("R7 queue drained", W'(exp_q.size()), '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule